// File: doc/BRIEF.md
# Serial Link Bring-up and Break Sequencer

This block owns the pins of a two-wire master link (a clock line and a single data line) together with the side-band outputs that surround them: a drive indicator that enables the data pad and the level translator, a link enable and a path-select mux. It moves those pins through a power-up flush, through a break pattern that resets the far end, and through a link-enable step. It does not carry commands or decode responses; a separate transfer engine does that once the link is up.

Three one-cycle requests start the work: init, break and link enable. Init claims the mux and data line, parks the data high and clocks 5000 pulses to clear stale bits out of the slave. Break walks the data line low, high, then low again while it clocks fixed pulse counts in each phase. It then waits a fixed number of microsecond ticks so that the slave's reset can settle. Link enable simply raises the enable output. While a sequence runs, `busy_o` is high and every request is dropped; `done_o` marks the end of each command for one cycle.

Top module: `link_seq_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the clock output is high, the data output is low and not driven, the enable and mux outputs are low, and busy and done are low.
- R2: In the cycle after an accepted init request, mux is high, clock is high, data is high, the drive indicator is high, enable is low and busy is high. Once raised, mux and the drive indicator stay high.
- R3: An init issues exactly 5000 clock pulses with data high. It then ends with done.
- R4: Each clock pulse is a low phase and then a high phase of PHASE_CYCLES cycles each. Every sequence opens with one high phase before its first low phase. The clock is high whenever busy is low, and data only changes while the clock is high. With PHASE_CYCLES=1, done follows an init request by 10002 cycles.
- R5: A break clocks 50 pulses with data low, then 256 pulses with data high, with the drive indicator high.
- R6: After the high phase of a break, data goes low for a 16-pulse echo gap and then a 16000-pulse settle phase. That is 16016 pulses in a row with data low.
- R7: After its last clock pulse, a break waits for exactly 200 microsecond ticks and raises done in the cycle after the tick that completes the count. Ticks that arrive while clocks are still running do not count.
- R8: A link-enable request raises the enable output in the next cycle and pulses done in that same cycle, without raising busy. Enable stays high through breaks, and only a later init lowers it.
- R9: Requests that arrive while busy is high are dropped. They change neither the pulse pattern, nor the enable output, nor the number of done pulses.
- R10: When more than one request arrives in the same idle cycle, init wins over break and break wins over link enable.
- R11: Done is high for exactly one cycle at the end of each command, in the cycle where busy is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req_i | input | 1 | Start the power-up flush |
| break_req_i | input | 1 | Start the break pattern |
| enable_req_i | input | 1 | Raise the link enable |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| lclk_o | output | 1 | Link clock pin level |
| ldata_o | output | 1 | Link data pin level when driven |
| ldrive_o | output | 1 | Data pad drive enable and translator direction |
| lenable_o | output | 1 | Link enable pin |
| lmux_o | output | 1 | Path-select mux pin |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle end-of-command strobe |

## Verification
The bench runs an init that is requested together with a break. The resulting 5000-pulse run with data high shows that priority went to init and not to break. A lone break gives three runs of low, high and low data, each with its own pulse count, so a wrong length or a merged or split phase shows up as a run mismatch. Microsecond ticks are sent during the break's clocking and then a counted 200 after it, which separates a wait that counts only its own ticks from one that counts early ticks or is off by one. Stray init, break and enable requests sent in the middle of sequences must leave the run pattern, the enable pin and the done count unchanged, and a final init shows that enable is cleared again.

// File: rtl/link_seq_pkg.sv
// Shared types for the link bring-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package link_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLOCK,
        ST_WAIT
    } seq_state_e;

    typedef enum logic [2:0] {
        SEG_FLUSH,
        SEG_PREP,
        SEG_BREAK,
        SEG_ECHO,
        SEG_SETTLE
    } seg_e;

endpackage

// File: rtl/link_seq_phase.sv
// Phase timer: strobes phase_end_o on the last cycle of every clock
// phase while run_i is high, each phase lasting PHASE_CYCLES cycles.
// Assumes: PHASE_CYCLES >= 1; dropping run_i restarts the phase count.
module link_seq_phase #(
    parameter int PHASE_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic phase_end_o
);
    localparam int PC_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [PC_W-1:0] LAST = PC_W'(PHASE_CYCLES - 1);

    logic [PC_W-1:0] pc;

    // Count cycles inside a phase and wrap at the end of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            pc <= '0;
        end else if (pc == LAST) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    assign phase_end_o = run_i && (pc == LAST);
endmodule

// File: rtl/link_seq_count.sv
// Event counter: clears on clear_i (which has priority) and steps on incr_i.
// Used both for clock pulses per segment and for microsecond ticks.
// Assumes: the owner never asks for more than 2**W - 1 events.
module link_seq_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         incr_i,
    output logic [W-1:0] count_o
);
    // Hold, clear or step the event count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_o <= '0;
        end else if (incr_i) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/link_seq_ctrl.sv
// Link bring-up and break sequencer. Drives the link clock, data, drive
// indicator, enable and mux pins through the init flush, the break pattern
// and the link-enable step, and reports busy/done.
// Assumes: one-cycle requests, every pulse count and WAIT_US >= 1,
// us_tick_i is a single-cycle strobe.
module link_seq_ctrl
    import link_seq_pkg::*;
#(
    parameter int PHASE_CYCLES  = 1,
    parameter int INIT_PULSES   = 5000,
    parameter int PREP_PULSES   = 50,
    parameter int BREAK_PULSES  = 256,
    parameter int ECHO_PULSES   = 16,
    parameter int SETTLE_PULSES = 16000,
    parameter int WAIT_US       = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_req_i,
    input  logic break_req_i,
    input  logic enable_req_i,
    input  logic us_tick_i,
    output logic lclk_o,
    output logic ldata_o,
    output logic ldrive_o,
    output logic lenable_o,
    output logic lmux_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W  = $clog2(INIT_PULSES + PREP_PULSES + BREAK_PULSES
                                   + ECHO_PULSES + SETTLE_PULSES + 1);
    localparam int WAIT_W = $clog2(WAIT_US + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_US - 1);

    seq_state_e state;
    seg_e       seg;

    logic              phase_end;
    logic [CNT_W-1:0]  pulses;
    logic [WAIT_W-1:0] ticks;
    logic [CNT_W-1:0]  target;
    logic idle, go_init, go_break, go_enable;
    logic seg_full, seg_step, pulse_inc, pulse_clr;
    logic tick_inc, tick_clr, wait_over;

    // Pulse count that closes each segment.
    function automatic logic [CNT_W-1:0] seg_len(input seg_e s);
        case (s)
            SEG_FLUSH:  return CNT_W'(INIT_PULSES);
            SEG_PREP:   return CNT_W'(PREP_PULSES);
            SEG_BREAK:  return CNT_W'(BREAK_PULSES);
            SEG_ECHO:   return CNT_W'(ECHO_PULSES);
            default:    return CNT_W'(SETTLE_PULSES);
        endcase
    endfunction

    // Request arbitration: init over break over link enable, idle only.
    always_comb begin
        idle      = (state == ST_IDLE);
        go_init   = idle && init_req_i;
        go_break  = idle && !init_req_i && break_req_i;
        go_enable = idle && !init_req_i && !break_req_i && enable_req_i;
    end

    // Segment progress and wait-window decoding.
    always_comb begin
        target    = seg_len(seg);
        seg_full  = (pulses == target);
        seg_step  = phase_end && lclk_o && seg_full;
        pulse_inc = phase_end && !lclk_o;
        pulse_clr = go_init || go_break || seg_step;
        tick_inc  = (state == ST_WAIT) && us_tick_i;
        tick_clr  = (state != ST_WAIT);
        wait_over = tick_inc && (ticks == WAIT_LAST);
    end

    link_seq_phase #(
        .PHASE_CYCLES(PHASE_CYCLES)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (state == ST_CLOCK),
        .phase_end_o(phase_end)
    );

    link_seq_count #(
        .W(CNT_W)
    ) u_pulses (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(pulse_clr),
        .incr_i (pulse_inc),
        .count_o(pulses)
    );

    link_seq_count #(
        .W(WAIT_W)
    ) u_ticks (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(tick_clr),
        .incr_i (tick_inc),
        .count_o(ticks)
    );

    // Sequencer state, segment walk and pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            seg       <= SEG_FLUSH;
            lclk_o    <= 1'b1;
            ldata_o   <= 1'b0;
            ldrive_o  <= 1'b0;
            lenable_o <= 1'b0;
            lmux_o    <= 1'b0;
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (go_init) begin
                        state     <= ST_CLOCK;
                        seg       <= SEG_FLUSH;
                        lmux_o    <= 1'b1;
                        lclk_o    <= 1'b1;
                        ldata_o   <= 1'b1;
                        ldrive_o  <= 1'b1;
                        lenable_o <= 1'b0;
                        busy_o    <= 1'b1;
                    end else if (go_break) begin
                        state    <= ST_CLOCK;
                        seg      <= SEG_PREP;
                        lclk_o   <= 1'b1;
                        ldata_o  <= 1'b0;
                        ldrive_o <= 1'b1;
                        busy_o   <= 1'b1;
                    end else if (go_enable) begin
                        lenable_o <= 1'b1;
                        done_o    <= 1'b1;
                    end
                end
                ST_CLOCK: begin
                    if (phase_end) begin
                        if (!lclk_o) begin
                            lclk_o <= 1'b1;
                        end else if (!seg_full) begin
                            lclk_o <= 1'b0;
                        end else begin
                            case (seg)
                                SEG_PREP: begin
                                    seg     <= SEG_BREAK;
                                    ldata_o <= 1'b1;
                                end
                                SEG_BREAK: begin
                                    seg     <= SEG_ECHO;
                                    ldata_o <= 1'b0;
                                end
                                SEG_ECHO: begin
                                    seg <= SEG_SETTLE;
                                end
                                SEG_SETTLE: begin
                                    state <= ST_WAIT;
                                end
                                default: begin
                                    state  <= ST_IDLE;
                                    busy_o <= 1'b0;
                                    done_o <= 1'b1;
                                end
                            endcase
                        end
                    end
                end
                ST_WAIT: begin
                    if (wait_over) begin
                        state  <= ST_IDLE;
                        busy_o <= 1'b0;
                        done_o <= 1'b1;
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    busy_o <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/link_seq_ctrl_chk.sv
// Property checker for link_seq_ctrl, attached by bind below.
// Assumes: synchronous active-low reset on rst_n.
module link_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic init_req_i,
    input logic break_req_i,
    input logic enable_req_i,
    input logic lclk_o,
    input logic ldata_o,
    input logic ldrive_o,
    input logic lenable_o,
    input logic lmux_o,
    input logic busy_o,
    input logic done_o
);
    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> lclk_o); // R4

    AST_DATA_MOVES_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ldata_o) |-> (lclk_o && $past(lclk_o))); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R11

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R11

    AST_ENABLE_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lenable_o) |-> $past(enable_req_i && !init_req_i && !break_req_i && !busy_o)); // R10

    AST_ENABLE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(lenable_o)); // R9

    AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lmux_o) |-> lmux_o); // R2

    AST_DRIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ldrive_o) |-> ldrive_o); // R2
endmodule

bind link_seq_ctrl link_seq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_req_i  (init_req_i),
    .break_req_i (break_req_i),
    .enable_req_i(enable_req_i),
    .lclk_o      (lclk_o),
    .ldata_o     (ldata_o),
    .ldrive_o    (ldrive_o),
    .lenable_o   (lenable_o),
    .lmux_o      (lmux_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/link_seq_ctrl_test.sv
// Scoreboard bench for link_seq_ctrl: driver tasks queue expected pulse runs
// and done strobes, a monitor groups clock rises by data level and compares.
module link_seq_ctrl_test;
    localparam int INIT_N  = 5000;
    localparam int PREP_N  = 50;
    localparam int BRK_N   = 256;
    localparam int LOW_N   = 16 + 16000;
    localparam int WAIT_N  = 200;

    typedef struct {
        bit    is_done;
        bit    val;
        int    cnt;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_req = 1'b0;
    logic break_req = 1'b0;
    logic enable_req = 1'b0;
    logic us_tick = 1'b0;
    logic lclk_o, ldata_o, ldrive_o, lenable_o, lmux_o, busy_o, done_o;

    int    errors = 0;
    int    checks = 0;
    item_t exp_q[$];
    bit    mon_prev = 1'b1;
    int    run_cnt = 0;
    bit    run_val = 1'b0;

    always #4 clk = ~clk;

    link_seq_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_req_i  (init_req),
        .break_req_i (break_req),
        .enable_req_i(enable_req),
        .us_tick_i   (us_tick),
        .lclk_o      (lclk_o),
        .ldata_o     (ldata_o),
        .ldrive_o    (ldrive_o),
        .lenable_o   (lenable_o),
        .lmux_o      (lmux_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input bit is_done, input bit val, input int cnt, input string tag);
        item_t e;
        e.is_done = is_done;
        e.val = val;
        e.cnt = cnt;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic flush_run();
        item_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected pulse run (level*1e6+pulses)",
                  run_val * 1000000 + run_cnt, 0);
        end else begin
            e = exp_q.pop_front();
            check(!e.is_done && e.val == run_val && e.cnt == run_cnt, e.tag,
                  "pulse run (level*1e6+pulses)",
                  run_val * 1000000 + run_cnt, e.val * 1000000 + e.cnt);
        end
        run_cnt = 0;
    endtask

    // Monitor: group clock rises into runs of equal data level, pop on done.
    initial begin : monitor
        item_t e;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (lclk_o && !mon_prev) begin
                if (run_cnt > 0 && ldata_o != run_val) flush_run();
                if (run_cnt == 0) run_val = ldata_o;
                run_cnt++;
            end
            mon_prev = lclk_o;
            if (done_o) begin
                if (run_cnt > 0) flush_run();
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.is_done, e.tag, "done strobe where a run was due", 0, 1);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic wait_done(output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (!done_o);
    endtask

    // Init: optional simultaneous break (R10), stray requests mid-run (R9).
    task automatic run_init(input bit with_break);
        int cyc;
        push(1'b0, 1'b1, INIT_N, "R3");
        push(1'b1, 1'b0, 0, "R3");
        @(negedge clk);
        init_req = 1'b1;
        break_req = with_break;
        @(negedge clk);
        init_req = 1'b0;
        break_req = 1'b0;
        check(lmux_o && lclk_o && ldata_o && ldrive_o && busy_o, "R2",
              "mux,clk,data,drive,busy after init", {lmux_o, lclk_o, ldata_o, ldrive_o, busy_o}, 5'b11111);
        check(lenable_o == 1'b0, "R8", "enable after init", lenable_o, 0);
        repeat (99) @(negedge clk);
        break_req = 1'b1;
        enable_req = 1'b1;
        @(negedge clk);
        break_req = 1'b0;
        enable_req = 1'b0;
        wait_done(cyc);
        check(cyc + 101 == 10002, "R4", "cycles from init request to done", cyc + 101, 10002);
        check(lenable_o == 1'b0, "R9", "enable after ignored request", lenable_o, 0);
        check(lclk_o && ldata_o && !busy_o, "R3", "clk,data,busy at done",
              {lclk_o, ldata_o, busy_o}, 3'b110);
        @(negedge clk);
        check(done_o == 1'b0, "R11", "done width", done_o, 0);
    endtask

    task automatic run_enable();
        push(1'b1, 1'b0, 0, "R8");
        @(negedge clk);
        enable_req = 1'b1;
        @(negedge clk);
        enable_req = 1'b0;
        check(lenable_o && done_o && !busy_o, "R8", "enable,done,busy after enable request",
              {lenable_o, done_o, busy_o}, 3'b110);
        @(negedge clk);
        check(!done_o && lenable_o, "R11", "done,enable one cycle later", {done_o, lenable_o}, 2'b01);
    endtask

    // Break: ticks during clocking (R7), stray requests (R9), exact wait.
    task automatic run_break();
        int  rises;
        int  cyc;
        bit  prev;
        bit  early;
        push(1'b0, 1'b0, PREP_N, "R5");
        push(1'b0, 1'b1, BRK_N, "R5");
        push(1'b0, 1'b0, LOW_N, "R6");
        push(1'b1, 1'b0, 0, "R7");
        @(negedge clk);
        break_req = 1'b1;
        @(negedge clk);
        break_req = 1'b0;
        check(ldrive_o && !ldata_o && busy_o && lclk_o, "R5", "drive,data,busy,clk after break",
              {ldrive_o, ldata_o, busy_o, lclk_o}, 4'b1011);
        check(lenable_o && lmux_o, "R8", "enable,mux kept by break", {lenable_o, lmux_o}, 2'b11);
        rises = 0;
        cyc = 0;
        prev = lclk_o;
        while (rises < PREP_N + BRK_N + LOW_N) begin
            @(negedge clk);
            cyc++;
            if (lclk_o && !prev) rises++;
            prev = lclk_o;
            us_tick = (cyc % 10 == 0);
            init_req = (cyc == 300);
            break_req = (cyc == 700);
            enable_req = (cyc == 900);
        end
        us_tick = 1'b0;
        init_req = 1'b0;
        break_req = 1'b0;
        enable_req = 1'b0;
        repeat (3) @(negedge clk);
        check(busy_o && !done_o, "R7", "busy,done after last pulse", {busy_o, done_o}, 2'b10);
        early = 1'b0;
        for (int k = 0; k < WAIT_N; k++) begin
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            if (k < WAIT_N - 1) begin
                if (done_o) early = 1'b1;
                repeat (4) begin
                    @(negedge clk);
                    if (done_o) early = 1'b1;
                end
            end
        end
        check(!early, "R7", "done before last tick", early, 0);
        check(done_o && !busy_o, "R7", "done,busy after last tick", {done_o, busy_o}, 2'b10);
        @(negedge clk);
        check(!done_o && lclk_o && !ldata_o && ldrive_o, "R11", "done,clk,data,drive after break",
              {done_o, lclk_o, ldata_o, ldrive_o}, 4'b0101);
    endtask

    initial begin : driver
        repeat (3) @(negedge clk);
        check(lclk_o && !ldata_o && !ldrive_o && !lenable_o && !lmux_o && !busy_o && !done_o,
              "R1", "pins in reset", {lclk_o, ldata_o, ldrive_o, lenable_o, lmux_o, busy_o, done_o}, 7'b1000000);
        rst_n = 1'b1;
        @(negedge clk);
        check(lclk_o && !ldata_o && !ldrive_o && !lenable_o && !lmux_o && !busy_o && !done_o,
              "R1", "pins after reset", {lclk_o, ldata_o, ldrive_o, lenable_o, lmux_o, busy_o, done_o}, 7'b1000000);
        run_init(1'b1);   // R10: init wins over a break in the same cycle
        run_enable();
        run_break();
        run_init(1'b0);   // R8: a later init lowers enable
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R9", "expected items left over", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule